// File: doc/BRIEF.md
# Shared-Period Pin Debounce Filter

This block cleans up the already-synchronised input levels of a bank of general-purpose pins. Every pin carries a 2-bit selector. A selector of zero lets the raw level straight through. Any other value ties the pin to one of three programmable period registers, and those registers are shared by the whole bank. A debounced pin changes its output only after the raw level has held a new value for the selected number of clock cycles. Any number of pins can point at the same period register at once.

The period registers are written and read over a small register bus with single-cycle writes and combinational reads. The selector vector and the raw pin levels come from neighbouring logic. The filtered levels go on to interrupt detection and readback logic. Pins that are output-only are set by a parameter mask and always pass straight through.

Top module: `pin_debounce`

## Requirements
- R1: A capable pin whose selector is 0 drives its filtered output equal to its raw input in the same cycle, with no delay.
- R2: The three period registers are 32 bits wide and sit at byte addresses 0x00, 0x04 and 0x08. A write with reg_we_i high updates the register on the next rising edge. reg_rdata_o combinationally returns the register at reg_addr_i. Any other address, including 0x0C and any address that is not word-aligned, ignores writes and reads as 0.
- R3: Selector 1 uses the register at 0x04, selector 2 uses the register at 0x00, and selector 3 uses the register at 0x08.
- R4: On a debounced pin, the output takes the new raw value on the P-th consecutive rising edge at which the raw input differs from the output. P is the selected period.
- R5: If the raw input returns to the output value before P edges have passed, the count restarts from zero and the output does not change.
- R6: A period of 0 behaves exactly like a period of 1: the output updates on the first edge that sees the difference.
- R7: Pins that select the same register share its period, and each pin keeps its own independent count.
- R8: A pin that is cleared in the IN_CAP_MASK parameter ignores its selector and always passes its raw input through. Bit 7 is cleared by default.
- R9: A change of selector on a debounced pin restarts that pin's count at that edge and leaves its output unchanged for that edge.
- R10: A write to a period register restarts the count of every debounced pin that selects that register at that edge. The output of those pins is unchanged for that edge, and the count after the edge uses the new period.
- R11: While reset is low, and in the first cycle after it is released, every filtered output equals its raw input. On the first edge after release, each pin's internal state loads the raw value and every count clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Period register write strobe |
| reg_addr_i | input | ADDR_W (4) | Byte address for both read and write |
| reg_wdata_i | input | PRD_W (32) | Write data |
| reg_rdata_o | output | PRD_W (32) | Read data for reg_addr_i |
| sel_i | input | 2*N_PINS (16) | Per-pin period selector, pin g in bits [2g+1:2g] |
| raw_i | input | N_PINS (8) | Synchronised raw pin levels |
| filt_o | output | N_PINS (8) | Filtered pin levels |

## Verification
Two events can fall on the same edge. A pin's count can reach its period in the very cycle that its selector changes, or in the very cycle that software rewrites the period register it uses. The bench provokes both on purpose: it toggles pins, lets them count partway, and then changes a selector or writes a period. A long random phase adds further selector changes and register writes with small periods while pins are mid-count. A behavioural model applies the restart rule ahead of the completion rule, and its output is compared with the design on every clock. Any disagreement about which of the two events won shows up as a mismatch in the filtered vector.

// File: rtl/pin_debounce_pkg.sv
package pin_debounce_pkg;
  localparam int unsigned NUM_PRD = 3;
  localparam int unsigned SLOT_W  = 2;

  typedef enum logic [1:0] {
    SEL_OFF = 2'd0,
    SEL_B   = 2'd1,
    SEL_A   = 2'd2,
    SEL_C   = 2'd3
  } dbnc_sel_e;

  // selector -> period slot (slot index = byte address / 4)
  function automatic logic [SLOT_W-1:0] sel_to_slot(input logic [1:0] sel);
    case (sel)
      SEL_B:   sel_to_slot = 2'd1;
      SEL_A:   sel_to_slot = 2'd0;
      SEL_C:   sel_to_slot = 2'd2;
      default: sel_to_slot = 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/dbnc_prd_regs.sv
module dbnc_prd_regs
  import pin_debounce_pkg::*;
#(
  parameter int unsigned PRD_W  = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            we_i,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [PRD_W-1:0]                wdata_i,
  output logic [PRD_W-1:0]                rdata_o,
  output logic [NUM_PRD-1:0][PRD_W-1:0]   prd_o,
  output logic [NUM_PRD-1:0]              hit_o
);
  localparam int unsigned LSB_W = 2;

  logic                      aligned;
  logic [NUM_PRD-1:0]        rd_sel;
  logic [NUM_PRD-1:0][PRD_W-1:0] prd_q;

  assign aligned = (addr_i[LSB_W-1:0] == '0) && ((addr_i >> (LSB_W + SLOT_W)) == '0);

  for (genvar r = 0; r < NUM_PRD; r++) begin : g_slot
    assign rd_sel[r] = aligned && (addr_i[LSB_W +: SLOT_W] == SLOT_W'(r));
    assign hit_o[r]  = we_i && rd_sel[r];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       prd_q[r] <= '0;
      else if (hit_o[r]) prd_q[r] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int r = 0; r < NUM_PRD; r++) begin
      if (rd_sel[r]) rdata_o = prd_q[r];
    end
  end

  assign prd_o = prd_q;
endmodule

// File: rtl/dbnc_pin_filter.sv
module dbnc_pin_filter
  import pin_debounce_pkg::*;
#(
  parameter int unsigned PRD_W = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          primed_i,
  input  logic                          raw_i,
  input  logic [1:0]                    sel_i,
  input  logic [NUM_PRD-1:0][PRD_W-1:0] prd_i,
  input  logic [NUM_PRD-1:0]            hit_i,
  output logic                          filt_o
);
  logic [1:0]        sel_q;
  logic              lvl_q;
  logic [PRD_W-1:0]  cnt_q;
  logic [SLOT_W-1:0] slot;
  logic [PRD_W-1:0]  period;
  logic [PRD_W-1:0]  limit;
  logic              slot_hit;
  logic              bypass;
  logic              restart;

  assign slot = sel_to_slot(sel_i);

  always_comb begin
    period   = prd_i[0];
    slot_hit = hit_i[0];
    case (slot)
      2'd1: begin period = prd_i[1]; slot_hit = hit_i[1]; end
      2'd2: begin period = prd_i[2]; slot_hit = hit_i[2]; end
      default: ;
    endcase
  end

  // period 0 acts as period 1
  assign limit   = (period == '0) ? PRD_W'(1) : period;
  assign bypass  = (sel_i == SEL_OFF) || !primed_i;
  assign restart = (sel_i != sel_q) || slot_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= SEL_OFF;
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      sel_q <= sel_i;
      if (bypass) begin
        lvl_q <= raw_i;
        cnt_q <= '0;
      end else if (restart || (raw_i == lvl_q)) begin
        cnt_q <= '0;
      end else if (cnt_q >= limit - PRD_W'(1)) begin
        lvl_q <= raw_i;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + PRD_W'(1);
      end
    end
  end

  assign filt_o = bypass ? raw_i : lvl_q;
endmodule

// File: rtl/pin_debounce.sv
module pin_debounce
  import pin_debounce_pkg::*;
#(
  parameter int unsigned         N_PINS      = 8,
  parameter int unsigned         PRD_W       = 32,
  parameter int unsigned         ADDR_W      = 4,
  parameter logic [N_PINS-1:0]   IN_CAP_MASK = {1'b0, {(N_PINS-1){1'b1}}}
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  reg_we_i,
  input  logic [ADDR_W-1:0]     reg_addr_i,
  input  logic [PRD_W-1:0]      reg_wdata_i,
  output logic [PRD_W-1:0]      reg_rdata_o,
  input  logic [2*N_PINS-1:0]   sel_i,
  input  logic [N_PINS-1:0]     raw_i,
  output logic [N_PINS-1:0]     filt_o
);
  logic                          primed_q;
  logic [NUM_PRD-1:0][PRD_W-1:0] prd;
  logic [NUM_PRD-1:0]            prd_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) primed_q <= 1'b0;
    else         primed_q <= 1'b1;
  end

  dbnc_prd_regs #(
    .PRD_W (PRD_W),
    .ADDR_W(ADDR_W)
  ) i_prd_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we_i),
    .addr_i (reg_addr_i),
    .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o),
    .prd_o  (prd),
    .hit_o  (prd_hit)
  );

  for (genvar g = 0; g < N_PINS; g++) begin : g_pin
    logic [1:0] sel_eff;
    // output-only pins are forced to bypass
    assign sel_eff = IN_CAP_MASK[g] ? sel_i[2*g +: 2] : SEL_OFF;

    dbnc_pin_filter #(
      .PRD_W(PRD_W)
    ) i_filter (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .primed_i(primed_q),
      .raw_i   (raw_i[g]),
      .sel_i   (sel_eff),
      .prd_i   (prd),
      .hit_i   (prd_hit),
      .filt_o  (filt_o[g])
    );
  end
endmodule

// File: rtl/pin_debounce_chk.sv
module pin_debounce_chk #(
  parameter int unsigned         N_PINS      = 8,
  parameter int unsigned         PRD_W       = 32,
  parameter int unsigned         ADDR_W      = 4,
  parameter logic [N_PINS-1:0]   IN_CAP_MASK = {1'b0, {(N_PINS-1){1'b1}}}
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  reg_we_i,
  input logic [ADDR_W-1:0]     reg_addr_i,
  input logic [PRD_W-1:0]      reg_wdata_i,
  input logic [PRD_W-1:0]      reg_rdata_o,
  input logic [2*N_PINS-1:0]   sel_i,
  input logic [N_PINS-1:0]     raw_i,
  input logic [N_PINS-1:0]     filt_o
);
  function automatic logic [ADDR_W-1:0] sel_addr(input logic [1:0] s);
    case (s)
      2'd1:    sel_addr = ADDR_W'(4);
      2'd2:    sel_addr = ADDR_W'(0);
      default: sel_addr = ADDR_W'(8);
    endcase
  endfunction

  logic addr_ok;
  assign addr_ok = (reg_addr_i == ADDR_W'(0)) || (reg_addr_i == ADDR_W'(4)) ||
                   (reg_addr_i == ADDR_W'(8));

  p_rdback_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && addr_ok) |=>
      ((reg_addr_i != $past(reg_addr_i)) || (reg_rdata_o == $past(reg_wdata_i))));

  p_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == ADDR_W'(12)) |-> (reg_rdata_o == '0));

  p_rstpass_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (filt_o == raw_i));

  for (genvar g = 0; g < N_PINS; g++) begin : g_pin
    logic dbn;
    assign dbn = IN_CAP_MASK[g] && (sel_i[2*g +: 2] != 2'd0);

    // R1 and R8: non-debounced pins are transparent
    p_pass_r1_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !dbn |-> (filt_o[g] == raw_i[g]));

    p_settle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && dbn && $past(dbn) && (filt_o[g] != $past(filt_o[g])))
        |-> (filt_o[g] == $past(raw_i[g])));

    p_selchg_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && dbn && (sel_i[2*g +: 2] != $past(sel_i[2*g +: 2])))
        |=> (!dbn || (filt_o[g] == $past(filt_o[g]))));

    p_prdwr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && dbn && reg_we_i && (reg_addr_i == sel_addr(sel_i[2*g +: 2])))
        |=> (!dbn || (filt_o[g] == $past(filt_o[g]))));
  end
endmodule

bind pin_debounce pin_debounce_chk #(
  .N_PINS     (N_PINS),
  .PRD_W      (PRD_W),
  .ADDR_W     (ADDR_W),
  .IN_CAP_MASK(IN_CAP_MASK)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .reg_rdata_o(reg_rdata_o),
  .sel_i      (sel_i),
  .raw_i      (raw_i),
  .filt_o     (filt_o)
);

// File: tb/test_pin_debounce.sv
`timescale 1ns/1ps
module test_pin_debounce;
  localparam int N = 8;
  localparam logic [N-1:0] CAP = 8'h7F;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [3:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [2*N-1:0] sel_i = '0;
  logic [N-1:0] raw_i = '0;
  logic [N-1:0] filt_o;

  int n_checks = 0;
  int n_fail = 0;

  // reference state
  logic [N-1:0] m_q = '0;
  longint       m_cnt [N];
  logic [1:0]   m_selp [N];
  bit           m_primed = 0;
  longint       m_per [3];

  always #2.5 clk_i = ~clk_i;

  pin_debounce i_pin_debounce (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .sel_i(sel_i),
    .raw_i(raw_i), .filt_o(filt_o)
  );

  // R3 mapping: sel 1 -> 0x04, sel 2 -> 0x00, sel 3 -> 0x08
  function automatic int slot_of(input logic [1:0] s);
    if (s == 2'd1) return 1;
    if (s == 2'd2) return 0;
    return 2;
  endfunction

  function automatic logic [N-1:0] exp_out();
    logic [N-1:0] e;
    for (int g = 0; g < N; g++) begin
      logic [1:0] s;
      s = CAP[g] ? sel_i[2*g +: 2] : 2'd0;
      e[g] = (!rst_ni || !m_primed || s == 2'd0) ? raw_i[g] : m_q[g];
    end
    return e;
  endfunction

  function automatic logic [31:0] exp_rd();
    if (reg_addr_i[1:0] == 2'b00 && reg_addr_i[3:2] != 2'b11)
      return 32'(m_per[reg_addr_i[3:2]]);
    return 32'd0;
  endfunction

  task automatic tick(input string tag);
    logic [N-1:0] nq;
    longint ncnt [N];
    logic [1:0] nsel [N];
    longint nper [3];
    nq = m_q;
    for (int k = 0; k < 3; k++) nper[k] = m_per[k];
    for (int g = 0; g < N; g++) begin
      logic [1:0] s;
      int sl;
      longint lim;
      bit rs;
      s = CAP[g] ? sel_i[2*g +: 2] : 2'd0;
      nsel[g] = s;
      ncnt[g] = 0;
      if (!m_primed || s == 2'd0) begin
        nq[g] = raw_i[g];
      end else begin
        sl  = slot_of(s);
        lim = (m_per[sl] == 0) ? 1 : m_per[sl];
        rs  = (s != m_selp[g]) || (reg_we_i && reg_addr_i == 4'(4*sl));
        if (rs || raw_i[g] == m_q[g]) ncnt[g] = 0;
        else if (m_cnt[g] + 1 >= lim) nq[g] = raw_i[g];
        else ncnt[g] = m_cnt[g] + 1;
      end
    end
    if (reg_we_i && reg_addr_i[1:0] == 2'b00 && reg_addr_i[3:2] != 2'b11)
      nper[reg_addr_i[3:2]] = longint'(reg_wdata_i);
    @(posedge clk_i);
    @(negedge clk_i);
    if (!rst_ni) begin
      m_q = '0; m_primed = 0;
      for (int g = 0; g < N; g++) begin m_cnt[g] = 0; m_selp[g] = 2'd0; end
      for (int k = 0; k < 3; k++) m_per[k] = 0;
    end else begin
      m_q = nq; m_primed = 1;
      for (int g = 0; g < N; g++) begin m_cnt[g] = ncnt[g]; m_selp[g] = nsel[g]; end
      for (int k = 0; k < 3; k++) m_per[k] = nper[k];
    end
    n_checks++;
    if (filt_o !== exp_out()) begin
      n_fail++;
      $display("FAIL %s filt_o actual=%h expected=%h", tag, filt_o, exp_out());
    end
    n_checks++;
    if (reg_rdata_o !== exp_rd()) begin
      n_fail++;
      $display("FAIL %s reg_rdata_o actual=%h expected=%h", tag, reg_rdata_o, exp_rd());
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input string tag);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    tick(tag);
    reg_we_i = 1'b0;
    tick(tag);
  endtask

  task automatic set_sel(input int g, input logic [1:0] s);
    sel_i[2*g +: 2] = s;
  endtask

  initial begin
    for (int g = 0; g < N; g++) begin m_cnt[g] = 0; m_selp[g] = 2'd0; end
    for (int k = 0; k < 3; k++) m_per[k] = 0;
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    // R11: outputs follow raw during reset, whatever the selectors
    raw_i = 8'hA5; sel_i = 16'h5555;
    repeat (3) tick("R11");
    raw_i = 8'h3C; tick("R11");
    rst_ni = 1'b1; tick("R11");
    raw_i = 8'hC3; tick("R11");
    sel_i = '0; tick("R11");

    // R2 register access
    wr(4'h0, 32'd5, "R2");
    wr(4'h4, 32'd3, "R2");
    wr(4'h8, 32'd2, "R2");
    wr(4'hC, 32'd77, "R2");
    wr(4'h5, 32'd99, "R2");
    for (int a = 0; a < 16; a += 4) begin reg_addr_i = 4'(a); tick("R2"); end

    // R3 R7: pins share periods
    set_sel(0, 2'd0); set_sel(1, 2'd1); set_sel(2, 2'd2); set_sel(3, 2'd3);
    set_sel(4, 2'd1); set_sel(5, 2'd1); set_sel(6, 2'd2); set_sel(7, 2'd3);
    repeat (2) tick("R3");
    raw_i = ~raw_i;
    repeat (8) tick("R4 R3 R7");

    // R5 glitch shorter than period
    raw_i = ~raw_i; repeat (2) tick("R5");
    raw_i = ~raw_i; repeat (7) tick("R5");

    // R6 period 0 and 1
    wr(4'h8, 32'd0, "R6");
    raw_i[3] = ~raw_i[3]; repeat (3) tick("R6");
    wr(4'h8, 32'd1, "R6");
    raw_i[3] = ~raw_i[3]; repeat (3) tick("R6");

    // R9 selector change mid-count
    raw_i = ~raw_i; repeat (2) tick("R9");
    set_sel(1, 2'd2); repeat (8) tick("R9");

    // R10 period write mid-count
    raw_i = ~raw_i; repeat (2) tick("R10");
    wr(4'h0, 32'd4, "R10");
    repeat (8) tick("R10");

    // R1 bypass pin toggles every cycle; R8 output-only pin too
    for (int i = 0; i < 6; i++) begin
      raw_i[0] = ~raw_i[0]; raw_i[7] = ~raw_i[7]; tick("R1 R8");
    end

    // mixed random traffic
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(0, 3) == 0) raw_i = raw_i ^ 8'($urandom_range(0, 255));
      if ($urandom_range(0, 15) == 0) set_sel($urandom_range(0, 7), 2'($urandom_range(0, 3)));
      reg_we_i = ($urandom_range(0, 19) == 0);
      reg_addr_i = 4'($urandom_range(0, 3) * 4);
      reg_wdata_i = 32'($urandom_range(0, 6));
      if (i == 300) rst_ni = 1'b0;
      if (i == 303) rst_ni = 1'b1;
      tick((i >= 300 && i < 306) ? "R11" : "R4 R5 R9 R10");
    end
    reg_we_i = 1'b0;
    tick("R4");

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule